// File: doc/BRIEF.md
# Light-Level Window Interrupt with Persistence Filter

This block raises an interrupt when an ambient light measurement leaves a programmed brightness window and stays outside it long enough. Each time the converter signals that a new channel 0 result is ready, the block compares that 16-bit result against a lower and an upper limit. Each limit is given as two byte fields. A result at or below the lower limit, or strictly above the upper limit, counts as outside the window.

A 4-bit persistence setting filters out brief excursions. The block counts back-to-back outside results. An inside result sets the count back to zero. The interrupt fires once the count reaches the setting. A setting of zero fires on every conversion whatever the limits are. The output is an active-low level that stays low until software pulses the clear input. A clear that arrives in the same cycle as a new firing conversion loses to that conversion. Dropping the enable forces the output high and empties the count.

Top module: `lux_window_irq`

## Requirements
- R1: The lower limit is `{lo_thr_msb, lo_thr_lsb}` and the upper limit is `{hi_thr_msb, hi_thr_lsb}`, with the msb byte in bits 15:8.
- R2: A result equal to or below the lower limit counts as outside the window.
- R3: A result equal to the upper limit counts as inside; a result one above it counts as outside.
- R4: With `persist` = 0, every conversion strobe with `irq_en` = 1 drives `irq_n` low in the next cycle, for any result.
- R5: With `persist` = 1, a single outside result drives `irq_n` low in the cycle after its strobe.
- R6: With `persist` = N (2..15), `irq_n` goes low only after N consecutive outside results; an inside result resets the run to zero.
- R7: Once low, `irq_n` stays low until a cycle with `irq_clr` = 1; it is high in the following cycle unless R8 applies.
- R8: When `irq_clr` and a firing conversion strobe arrive in the same cycle, `irq_n` is low in the next cycle.
- R9: While `irq_en` = 0, `irq_n` is high one cycle later and the run count is zero, so after re-enabling a fresh run of N outside results is needed.
- R10: The run count saturates at 15 and does not wrap. With `persist` = 15, every outside result after the fifteenth fires again.
- R11: During and right after synchronous reset (`rst` = 1), `irq_n` is high and the run count is zero.
- R12: Without a strobe and without a clear, `irq_n` does not change, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a new channel 0 result is valid |
| ch0_val | input | 16 | Channel 0 conversion result |
| lo_thr_lsb | input | 8 | Lower limit, bits 7:0 |
| lo_thr_msb | input | 8 | Lower limit, bits 15:8 |
| hi_thr_lsb | input | 8 | Upper limit, bits 7:0 |
| hi_thr_msb | input | 8 | Upper limit, bits 15:8 |
| persist | input | 4 | Consecutive outside results needed; 0 = every conversion |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | One-cycle clear pulse |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The bench builds the block with its default widths: a 16-bit result and a 4-bit persistence field. With these widths the largest setting, 15, can be reached in fifteen strobes. That keeps the saturation boundary within reach: a wrapping 4-bit counter would stop refiring on the sixteenth result. The 16-bit limits use distinct high and low bytes, so a swap of the byte fields changes which results count as inside the window.

// File: rtl/lwi_pkg.sv
package lwi_pkg;

    // Per-conversion comparison outcome against the two limits.
    typedef struct packed {
        logic at_or_below_lo;
        logic above_hi;
    } win_flags_t;

    function automatic logic is_outside(input win_flags_t f);
        return f.at_or_below_lo | f.above_hi;
    endfunction

endpackage

// File: rtl/lwi_window_cmp.sv
module lwi_window_cmp
    import lwi_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] lo_lim,
    input  logic [DATA_W-1:0] hi_lim,
    output win_flags_t        flags
);
    // Lower side is inclusive, upper side strict.
    always_comb begin
        flags.at_or_below_lo = (sample <= lo_lim);
        flags.above_hi       = (sample >  hi_lim);
    end
endmodule

// File: rtl/lwi_persist_ctr.sv
module lwi_persist_ctr #(
    parameter int PERS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              strobe,
    input  logic              outside,
    input  logic [PERS_W-1:0] setting,
    output logic              fire
);
    localparam logic [PERS_W-1:0] CNT_MAX = {PERS_W{1'b1}};

    logic [PERS_W-1:0] run_q;
    logic [PERS_W-1:0] run_nxt;

    always_comb begin
        if (!outside)
            run_nxt = '0;
        else if (run_q == CNT_MAX)
            run_nxt = CNT_MAX;
        else
            run_nxt = run_q + 1'b1;
    end

    // A zero setting fires on every strobe; otherwise the run must reach it.
    always_comb begin
        fire = 1'b0;
        if (enable && strobe) begin
            if (setting == '0)
                fire = 1'b1;
            else
                fire = outside && (run_nxt >= setting);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable)
            run_q <= '0;
        else if (strobe)
            run_q <= run_nxt;
    end
endmodule

// File: rtl/lwi_irq_latch.sv
module lwi_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic set,
    input  logic clr,
    output logic pending
);
    // Set has priority over clear.
    always_ff @(posedge clk) begin
        if (rst || !enable)
            pending <= 1'b0;
        else if (set)
            pending <= 1'b1;
        else if (clr)
            pending <= 1'b0;
    end
endmodule

// File: rtl/lux_window_irq.sv
module lux_window_irq
    import lwi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PERS_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_done,
    input  logic [DATA_W-1:0]   ch0_val,
    input  logic [DATA_W/2-1:0] lo_thr_lsb,
    input  logic [DATA_W/2-1:0] lo_thr_msb,
    input  logic [DATA_W/2-1:0] hi_thr_lsb,
    input  logic [DATA_W/2-1:0] hi_thr_msb,
    input  logic [PERS_W-1:0]   persist,
    input  logic                irq_en,
    input  logic                irq_clr,
    output logic                irq_n
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] lo_lim;
    logic [DATA_W-1:0] hi_lim;
    win_flags_t        flags;
    logic              fire;
    logic              pending;

    // Limits assembled from their byte halves, upper half in the high bits.
    assign lo_lim = {lo_thr_msb, lo_thr_lsb};
    assign hi_lim = {hi_thr_msb, hi_thr_lsb};

    lwi_window_cmp #(.DATA_W(DATA_W)) u_cmp (
        .sample (ch0_val),
        .lo_lim (lo_lim),
        .hi_lim (hi_lim),
        .flags  (flags)
    );

    lwi_persist_ctr #(.PERS_W(PERS_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .enable  (irq_en),
        .strobe  (conv_done),
        .outside (is_outside(flags)),
        .setting (persist),
        .fire    (fire)
    );

    lwi_irq_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .enable  (irq_en),
        .set     (fire),
        .clr     (irq_clr),
        .pending (pending)
    );

    assign irq_n = ~pending;

    if (HALF_W * 2 != DATA_W) begin : g_width_check
        initial $error("DATA_W must be even");
    end
endmodule

// File: rtl/lwi_checker.sv
module lwi_checker #(
    parameter int DATA_W = 16,
    parameter int PERS_W = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                conv_done,
    input logic [DATA_W-1:0]   ch0_val,
    input logic [DATA_W/2-1:0] lo_thr_lsb,
    input logic [DATA_W/2-1:0] lo_thr_msb,
    input logic [PERS_W-1:0]   persist,
    input logic                irq_en,
    input logic                irq_clr,
    input logic                irq_n
);
    // R11: output released right after a reset cycle
    assert_reset_release_R11: assert property (@(posedge clk)
        rst |=> irq_n);

    // R9: disabling forces the output high
    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> irq_n);

    // R4: zero persistence fires on every strobe
    assert_zero_persist_fires_R4: assert property (@(posedge clk) disable iff (rst)
        (conv_done && irq_en && persist == '0) |=> !irq_n);

    // R2: single-shot fire at or below the lower limit
    assert_low_inclusive_R2: assert property (@(posedge clk) disable iff (rst)
        (conv_done && irq_en && persist == 1 &&
         ch0_val <= {lo_thr_msb, lo_thr_lsb}) |=> !irq_n);

    // R7: asserted level held without a clear
    assert_level_held_R7: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !irq_clr && irq_en) |=> !irq_n);

    // R7: clear without a strobe releases the output
    assert_clear_releases_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !conv_done) |=> irq_n);

    // R12: nothing changes without strobe or clear
    assert_no_strobe_stable_R12: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !irq_clr && irq_en) |=> $stable(irq_n));
endmodule

bind lux_window_irq lwi_checker #(.DATA_W(DATA_W), .PERS_W(PERS_W)) u_lwi_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_done  (conv_done),
    .ch0_val    (ch0_val),
    .lo_thr_lsb (lo_thr_lsb),
    .lo_thr_msb (lo_thr_msb),
    .persist    (persist),
    .irq_en     (irq_en),
    .irq_clr    (irq_clr),
    .irq_n      (irq_n)
);

// File: tb/test_lux_window_irq.sv
`timescale 1ns/1ps
module test_lux_window_irq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [15:0] ch0_val = '0;
    logic [7:0]  lo_thr_lsb = '0, lo_thr_msb = '0, hi_thr_lsb = '0, hi_thr_msb = '0;
    logic [3:0]  persist = '0;
    logic        irq_en = 1'b0;
    logic        irq_clr = 1'b0;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lux_window_irq i_lux_window_irq (
        .clk(clk), .rst(rst), .conv_done(conv_done), .ch0_val(ch0_val),
        .lo_thr_lsb(lo_thr_lsb), .lo_thr_msb(lo_thr_msb),
        .hi_thr_lsb(hi_thr_lsb), .hi_thr_msb(hi_thr_msb),
        .persist(persist), .irq_en(irq_en), .irq_clr(irq_clr), .irq_n(irq_n)
    );

    // Row: req[7:0] persist[3:0] lo[15:0] hi[15:0] val[15:0] clr exp_irq_n
    localparam int NV = 16;
    localparam logic [61:0] VEC [NV] = '{
        {8'd5,  4'd1, 16'h0100, 16'h0800, 16'h0400, 1'b0, 1'b1}, // R5 R1 inside
        {8'd2,  4'd1, 16'h0100, 16'h0800, 16'h0100, 1'b0, 1'b0}, // R2 equal low fires
        {8'd7,  4'd1, 16'h0100, 16'h0800, 16'h0400, 1'b1, 1'b1}, // R7 clear releases
        {8'd3,  4'd1, 16'h0100, 16'h0800, 16'h0800, 1'b0, 1'b1}, // R3 R1 equal high inside
        {8'd3,  4'd1, 16'h0100, 16'h0800, 16'h0801, 1'b0, 1'b0}, // R3 one above fires
        {8'd6,  4'd2, 16'h0100, 16'h0800, 16'h0400, 1'b1, 1'b1}, // R6 cleared, run 0
        {8'd6,  4'd2, 16'h0100, 16'h0800, 16'h0000, 1'b0, 1'b1}, // R6 run 1
        {8'd6,  4'd2, 16'h0100, 16'h0800, 16'h0400, 1'b0, 1'b1}, // R6 inside resets run
        {8'd6,  4'd2, 16'h0100, 16'h0800, 16'hFFFF, 1'b0, 1'b1}, // R6 run 1 again
        {8'd6,  4'd2, 16'h0100, 16'h0800, 16'h00FF, 1'b0, 1'b0}, // R6 run 2 fires
        {8'd7,  4'd2, 16'h0100, 16'h0800, 16'h0400, 1'b0, 1'b0}, // R7 level held
        {8'd4,  4'd0, 16'h0100, 16'h0800, 16'h0400, 1'b1, 1'b0}, // R4 R8 inside fires, beats clear
        {8'd7,  4'd3, 16'h0100, 16'h0800, 16'h0400, 1'b1, 1'b1}, // R7 cleared
        {8'd6,  4'd3, 16'h0100, 16'h0800, 16'h0050, 1'b0, 1'b1}, // R6 run 1
        {8'd6,  4'd3, 16'h0100, 16'h0800, 16'h0050, 1'b0, 1'b1}, // R6 run 2
        {8'd8,  4'd3, 16'h0100, 16'h0800, 16'h0050, 1'b1, 1'b0}  // R8 run 3 fires over clear
    };

    task automatic check(input string req, input logic exp);
        checks++;
        if (irq_n !== exp) begin
            errors++;
            $display("FAIL %s: irq_n=%b expected %b at %0t", req, irq_n, exp, $time);
        end
    endtask

    task automatic set_limits(input logic [15:0] lo, input logic [15:0] hi);
        {lo_thr_msb, lo_thr_lsb} = lo;
        {hi_thr_msb, hi_thr_lsb} = hi;
    endtask

    // One cycle with a strobe and optional clear; result visible one edge later.
    task automatic strobe(input logic [15:0] v, input logic c);
        @(negedge clk);
        ch0_val = v; conv_done = 1'b1; irq_clr = c;
        @(negedge clk);
        conv_done = 1'b0; irq_clr = 1'b0;
    endtask

    task automatic clear_only();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, done=0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", 1'b1);
        rst = 1'b0;
        irq_en = 1'b1;
        @(negedge clk);
        check("R11", 1'b1);

        for (int i = 0; i < NV; i++) begin
            logic [61:0] r;
            r = VEC[i];
            persist = r[53:50];
            set_limits(r[49:34], r[33:18]);
            strobe(r[17:2], r[1]);
            check($sformatf("R%0d row %0d", r[61:54], i), r[0]);
        end

        // R12: data changes with no strobe leave the output alone
        clear_only();
        persist = 4'd1;
        set_limits(16'h0100, 16'h0800);
        repeat (3) begin
            @(negedge clk);
            ch0_val = 16'h0000;
        end
        check("R12", 1'b1);

        // R9: disable forces high and empties the run
        strobe(16'h0000, 1'b0);
        check("R9 set", 1'b0);
        @(negedge clk); irq_en = 1'b0;
        @(negedge clk);
        check("R9 disabled", 1'b1);
        irq_en = 1'b1;
        persist = 4'd2;
        strobe(16'h0000, 1'b0);
        check("R9 run count restarted", 1'b1);
        @(negedge clk); irq_en = 1'b0;
        @(negedge clk); irq_en = 1'b1;
        strobe(16'h0000, 1'b0);
        check("R9 run emptied while disabled", 1'b1);
        strobe(16'h0000, 1'b0);
        check("R9 fresh run fires", 1'b0);

        // R10: saturation at 15
        clear_only();
        persist = 4'd15;
        strobe(16'h0400, 1'b0);
        for (int k = 1; k <= 14; k++) strobe(16'h0000, 1'b0);
        check("R10 fourteen outside", 1'b1);
        strobe(16'h0000, 1'b0);
        check("R10 fifteenth fires", 1'b0);
        for (int k = 0; k < 3; k++) begin
            clear_only();
            check("R7 clear", 1'b1);
            strobe(16'h0000, 1'b0);
            check("R10 saturated refire", 1'b0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule